// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block is a clocked front end for a 64K-word by 16-bit asynchronous static RAM. A client raises a request together with a direction bit, a word address, write data and a two-bit lane mask. The controller then plays out one memory cycle on the active-low chip, write and output enable pins and on two per-byte select pins. Once the cycle is over it returns a one-clock completion pulse, with registered read data for a read.

How long each phase lasts comes from nanosecond timing parameters divided by the clock period, rounded up, with at least one clock for any nonzero interval. Output enable is held high for the whole of a write, so the memory never drives the bus while the controller does. Every read ends with a quiet turnaround window, which gives the memory time to release the bus before the next cycle starts. The data bus is presented as separate outgoing data, an output-enable for it, and incoming data, so that a pad ring or a bench can form the bidirectional pin.

Top module: `sram_ctrl`

## Requirements
- R1: During and after reset, and whenever the controller is idle, chip enable, write enable, output enable and both byte selects are high, the outgoing data enable is low and busy is low.
- R2: In a write, output enable stays high from start to end. Write enable is low for exactly NWP clocks, where NWP is the largest of ceil(tWP/clk), ceil(tAW/clk)-1, ceil(tWC/clk)-2 and ceil(tDW/clk). That is 5 clocks with a 10 ns clock and the default fastest-grade numbers. The outgoing data is driven during every clock in which write enable is low, and during the clock after it rises.
- R3: Mask bit 0 selects data bits 7:0 through byte select 0, and mask bit 1 selects bits 15:8 through byte select 1. A select is low only while chip enable is low and its mask bit is 1. Only selected lanes are written. In read data, an unselected lane returns zero.
- R4: In a read, chip enable and output enable stay low and write enable stays high for NRD clocks, where NRD is the largest of ceil(tAA/clk), ceil(tOE/clk) and ceil(tRC/clk), which is 6 by default. The input bus is sampled at the clock edge that ends the last of those clocks.
- R5: From the fall of chip enable until its rise, the memory address and the byte selects keep the values taken when the request was accepted. Write enable rises at least one clock before chip enable rises.
- R6: Done is high for exactly one clock. It rises NWP+2 clock edges after a write is accepted and NRD edges after a read is accepted, and read data is valid while done is high.
- R7: A request seen while busy is high is ignored. It causes no memory access, and it changes neither the address nor the data of the cycle in progress.
- R8: After a read, chip enable and output enable stay high and busy stays high for NTA = ceil(tOHZ/clk) clocks (2 by default), starting with the done clock.
- R9: Chip enable is low for at least ceil(tRC/clk) clocks in every cycle: NWP+2 clocks for a write and NRD clocks for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Lane mask, bit 0 = low byte |
| busy | output | 1 | Cycle or turnaround in progress |
| done | output | 1 | One-clock completion pulse |
| rdData | output | 16 | Registered read data |
| sramAddr | output | 16 | Memory address |
| sramCeN | output | 1 | Chip enable, active low |
| sramWeN | output | 1 | Write enable, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramByteN | output | 2 | Byte selects, active low, bit 0 = low byte |
| sramDout | output | 16 | Data driven toward memory |
| sramDoutEn | output | 1 | Enable for the outgoing data drivers |
| sramDin | input | 16 | Data returned from memory |

## Verification
The assertions take a clean reset and a memory that behaves as an asynchronous part. They make no assumption about when requests arrive, because requests during a busy cycle must be ignored anyway. The stimulus applies inputs half a clock away from the active edge. A bench memory model stores only lanes whose select is low, and it does so at the rise of write enable. For lanes that are not selected it returns filler bytes, so a missing lane mask in the read path shows up in the data. The sweep covers every mask value across a spread of addresses that includes both ends of the address space. It also raises intruding requests during a busy write, so the ignore rule is exercised under real traffic.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef struct packed {
    logic chipEn;
    logic wrEn;
    logic rdEn;
    logic drive;
    logic load;
    logic capture;
  } ctlStrobe_t;

  // Clocks covering an interval; any nonzero interval takes at least one.
  function automatic int cyclesFor(input int ns, input int clkNs);
    if (ns <= 0) return 0;
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 55,
  parameter int T_WP_NS  = 45,
  parameter int T_AW_NS  = 50,
  parameter int T_DW_NS  = 25,
  parameter int T_AA_NS  = 55,
  parameter int T_OE_NS  = 30,
  parameter int T_OHZ_NS = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       busy,
  output logic       done,
  output ctlStrobe_t strobe
);

  localparam int C_RC  = cyclesFor(T_RC_NS, CLK_NS);
  localparam int C_WP  = cyclesFor(T_WP_NS, CLK_NS);
  localparam int C_AW  = cyclesFor(T_AW_NS, CLK_NS);
  localparam int C_DW  = cyclesFor(T_DW_NS, CLK_NS);
  localparam int C_AA  = cyclesFor(T_AA_NS, CLK_NS);
  localparam int C_OE  = cyclesFor(T_OE_NS, CLK_NS);
  localparam int C_OHZ = cyclesFor(T_OHZ_NS, CLK_NS);
  // Write: one setup clock, NWP pulse clocks, one recovery clock.
  localparam int NWP = maxOf(maxOf(maxOf(C_WP, C_DW), maxOf(C_AW - 1, C_RC - 2)), 1);
  localparam int NRD = maxOf(maxOf(maxOf(C_AA, C_OE), C_RC), 1);
  localparam int NTA = maxOf(C_OHZ, 1);
  localparam int CNT_MAX = maxOf(maxOf(NWP, NRD), NTA);
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_WPULSE, S_WREC, S_RDACT, S_TURN
  } state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (reqValid) begin
          state <= reqWrite ? S_SETUP : S_RDACT;
          cnt   <= reqWrite ? '0 : CNT_W'(NRD - 1);
        end
        S_SETUP: begin
          state <= S_WPULSE;
          cnt   <= CNT_W'(NWP - 1);
        end
        S_WPULSE: begin
          if (cnt == '0) state <= S_WREC;
          else cnt <= cnt - 1'b1;
        end
        S_WREC: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        S_RDACT: begin
          if (cnt == '0) begin
            state <= S_TURN;
            cnt   <= CNT_W'(NTA - 1);
            done  <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        S_TURN: begin
          if (cnt == '0) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load    = (state == S_IDLE) && reqValid;
    strobe.chipEn  = (state == S_SETUP) || (state == S_WPULSE) ||
                     (state == S_WREC)  || (state == S_RDACT);
    strobe.wrEn    = (state == S_WPULSE);
    strobe.rdEn    = (state == S_RDACT);
    strobe.drive   = (state == S_WPULSE) || (state == S_WREC);
    strobe.capture = (state == S_RDACT) && (cnt == '0);
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            strobe,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqBe,
  input  logic [DATA_W-1:0]     sramDin,
  output logic [DATA_W-1:0]     rdData,
  output logic [ADDR_W-1:0]     sramAddr,
  output logic [DATA_W/8-1:0]   sramByteN,
  output logic [DATA_W-1:0]     sramDout
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  beQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
    end else if (strobe.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      beQ    <= reqBe;
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [7:0] laneQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) laneQ <= '0;
      else if (strobe.capture) laneQ <= beQ[lane] ? sramDin[lane*8 +: 8] : 8'h00;
    end
    assign rdData[lane*8 +: 8] = laneQ;
    assign sramByteN[lane]     = ~(strobe.chipEn & beQ[lane]);
  end

  assign sramAddr = addrQ;
  assign sramDout = wdataQ;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 55,
  parameter int T_WP_NS  = 45,
  parameter int T_AW_NS  = 50,
  parameter int T_DW_NS  = 25,
  parameter int T_AA_NS  = 55,
  parameter int T_OE_NS  = 30,
  parameter int T_OHZ_NS = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqBe,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   rdData,
  output logic [ADDR_W-1:0]   sramAddr,
  output logic                sramCeN,
  output logic                sramWeN,
  output logic                sramOeN,
  output logic [DATA_W/8-1:0] sramByteN,
  output logic [DATA_W-1:0]   sramDout,
  output logic                sramDoutEn,
  input  logic [DATA_W-1:0]   sramDin
);

  ctlStrobe_t strobe;

  sram_ctrl_fsm #(
    .CLK_NS(CLK_NS), .T_RC_NS(T_RC_NS), .T_WP_NS(T_WP_NS), .T_AW_NS(T_AW_NS),
    .T_DW_NS(T_DW_NS), .T_AA_NS(T_AA_NS), .T_OE_NS(T_OE_NS), .T_OHZ_NS(T_OHZ_NS)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .busy(busy), .done(done), .strobe(strobe)
  );

  sram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBe(reqBe), .sramDin(sramDin), .rdData(rdData),
    .sramAddr(sramAddr), .sramByteN(sramByteN), .sramDout(sramDout)
  );

  assign sramCeN    = ~strobe.chipEn;
  assign sramWeN    = ~strobe.wrEn;
  assign sramOeN    = ~strobe.rdEn;
  assign sramDoutEn = strobe.drive;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 10,
  parameter int T_WP_NS = 45
) (
  input logic                clk,
  input logic                rstN,
  input logic                busy,
  input logic                done,
  input logic [ADDR_W-1:0]   sramAddr,
  input logic                sramCeN,
  input logic                sramWeN,
  input logic                sramOeN,
  input logic [DATA_W/8-1:0] sramByteN,
  input logic                sramDoutEn
);

  localparam int C_WP = cyclesFor(T_WP_NS, CLK_NS);

  logic [7:0] weLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) weLowCnt <= '0;
    else if (!sramWeN) weLowCnt <= weLowCnt + 1'b1;
    else weLowCnt <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sramCeN && sramWeN && sramOeN && !sramDoutEn && (&sramByteN)));

  p_we_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (weLowCnt >= 8'(C_WP)));

  p_no_contention_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sramDoutEn || !sramWeN) |-> sramOeN);

  p_drive_during_we_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> sramDoutEn);

  p_lane_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    sramCeN |-> (&sramByteN));

  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> ($stable(sramAddr) && $stable(sramByteN)));

  p_we_before_ce_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramCeN) |-> $past(sramWeN));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS), .T_WP_NS(T_WP_NS)
) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .sramAddr(sramAddr),
  .sramCeN(sramCeN), .sramWeN(sramWeN), .sramOeN(sramOeN),
  .sramByteN(sramByteN), .sramDoutEn(sramDoutEn)
);

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  // Expected phase counts from the default fastest-grade numbers at 10 ns.
  localparam int NWP = 5;   // max(ceil(45/10), ceil(50/10)-1, ceil(55/10)-2, ceil(25/10))
  localparam int NRD = 6;   // max(ceil(55/10), ceil(30/10), ceil(55/10))
  localparam int NTA = 2;   // ceil(20/10)
  localparam int NRC = 6;   // ceil(55/10)

  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0, reqWrite = 0;
  logic [15:0] reqAddr = 0, reqWdata = 0;
  logic [1:0]  reqBe = 0;
  logic        busy, done, sramCeN, sramWeN, sramOeN, sramDoutEn;
  logic [15:0] rdData, sramAddr, sramDout;
  logic [15:0] sramDin = 16'h0;
  logic [1:0]  sramByteN;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit [15:0] mem [bit [15:0]];
  bit [15:0] shadow [bit [15:0]];
  int writeCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl u_sram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .busy(busy),
    .done(done), .rdData(rdData), .sramAddr(sramAddr), .sramCeN(sramCeN),
    .sramWeN(sramWeN), .sramOeN(sramOeN), .sramByteN(sramByteN),
    .sramDout(sramDout), .sramDoutEn(sramDoutEn), .sramDin(sramDin)
  );

  // Memory model: lanes stored at the end of write, filler on idle lanes.
  always @(posedge sramWeN) begin
    if (!sramCeN && rstN) begin
      bit [15:0] w;
      w = mem.exists(sramAddr) ? mem[sramAddr] : 16'h0;
      if (!sramByteN[0]) w[7:0]  = sramDout[7:0];
      if (!sramByteN[1]) w[15:8] = sramDout[15:8];
      mem[sramAddr] = w;
      writeCount++;
    end
  end

  always @(negedge clk) begin
    bit [15:0] w;
    w = mem.exists(sramAddr) ? mem[sramAddr] : 16'h0;
    if (!sramCeN && !sramOeN && sramWeN) begin
      sramDin[7:0]  <= sramByteN[0] ? 8'hA5 : w[7:0];
      sramDin[15:8] <= sramByteN[1] ? 8'h5A : w[15:8];
    end else sramDin <= 16'hC3C3;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One transaction; intrude raises a foreign request while busy.
  task automatic run(input bit wr, input bit [15:0] a, input bit [15:0] d,
                     input bit [1:0] be, input bit intrude, output bit [15:0] rd);
    int n, weLow, ceLow, oeLow, wcStart;
    bit badAddr, badLane, badOe, badDrive, badRd;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    wcStart = writeCount;
    @(posedge clk);
    @(negedge clk);
    if (intrude) begin
      reqWrite = 1; reqAddr = a ^ 16'h8001; reqWdata = ~d; reqBe = 2'b11;
    end else reqValid = 0;
    n = 1; weLow = 0; ceLow = 0; oeLow = 0;
    badAddr = 0; badLane = 0; badOe = 0; badDrive = 0; badRd = 0;
    while (!done && n < 40) begin
      if (n == 3) reqValid = 0;
      if (!sramCeN) begin
        ceLow++;
        if (sramAddr != a) badAddr = 1;
        if (sramByteN != ~be) badLane = 1;
      end
      if (!sramWeN) begin
        weLow++;
        if (!sramDoutEn) badDrive = 1;
      end
      if (!sramOeN) oeLow++;
      if (wr && !sramOeN) badOe = 1;
      if (!wr && (!sramWeN || sramDoutEn)) badRd = 1;
      @(negedge clk);
      n++;
    end
    rd = rdData;
    chk(!badAddr, "R5 address held", 0, 0);
    chk(!badLane, "R3 byte selects follow mask", be, be);
    chk(ceLow >= NRC, "R9 chip enable low time", ceLow, NRC);
    if (wr) begin
      chk(n == NWP + 3, "R6 write done latency", n, NWP + 3);
      chk(weLow == NWP, "R2 write pulse clocks", weLow, NWP);
      chk(!badOe && !badDrive, "R2 OE high and data driven", badOe, 0);
      chk(ceLow == NWP + 2, "R9 write cycle length", ceLow, NWP + 2);
      chk(writeCount - wcStart == 1, "R7 single memory write", writeCount - wcStart, 1);
    end else begin
      chk(n == NRD + 1, "R6 read done latency", n, NRD + 1);
      chk(oeLow == NRD, "R4 output enable clocks", oeLow, NRD);
      chk(!badRd, "R4 WE high and bus released", badRd, 0);
      chk(writeCount == wcStart, "R7 read writes nothing", writeCount - wcStart, 0);
    end
    @(negedge clk);
    chk(!done, "R6 done one clock", done, 0);
    if (!wr) begin
      int t;
      bit loud;
      t = 1; loud = 0;
      while (busy && t < 20) begin
        if (!sramCeN || !sramOeN) loud = 1;
        @(negedge clk);
        t++;
      end
      chk(t == NTA && !loud, "R8 turnaround clocks", t, NTA);
    end
  endtask

  function automatic bit [15:0] pat(input int i);
    return 16'(i * 16'h3B1D + 16'h1234);
  endfunction

  initial begin
    bit [15:0] rd, a, exp;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(sramCeN && sramWeN && sramOeN && sramByteN == 2'b11 && !sramDoutEn && !busy,
        "R1 reset quiet", {sramCeN, sramWeN, sramOeN, sramByteN, sramDoutEn, busy}, 7'b1111100);
    rstN = 1;
    @(negedge clk);
    chk(!busy && sramCeN && !done, "R1 idle after reset", busy, 0);

    // Full-word writes then reads across the address space (R2, R4)
    for (int i = 0; i < 40; i++) begin
      a = (i == 0) ? 16'h0000 : (i == 39) ? 16'hFFFF : 16'(i * 1657);
      run(1, a, pat(i), 2'b11, 0, rd);
      shadow[a] = pat(i);
    end
    for (int i = 0; i < 40; i++) begin
      a = (i == 0) ? 16'h0000 : (i == 39) ? 16'hFFFF : 16'(i * 1657);
      run(0, a, 16'h0, 2'b11, 0, rd);
      chk(rd == shadow[a], "R4 read data", rd, shadow[a]);
    end

    // Lane masks on writes and reads (R3)
    for (int i = 0; i < 12; i++) begin
      for (int bw = 0; bw < 4; bw++) begin
        a = 16'(i * 1657);
        run(1, a, pat(i * 7 + bw + 100), 2'(bw), 0, rd);
        exp = shadow[a];
        if (bw[0]) exp[7:0]  = pat(i * 7 + bw + 100) >> 0;
        if (bw[1]) exp[15:8] = pat(i * 7 + bw + 100) >> 8;
        shadow[a] = exp;
        for (int br = 0; br < 4; br++) begin
          run(0, a, 16'h0, 2'(br), 0, rd);
          exp = shadow[a] & {{8{br[1]}}, {8{br[0]}}};
          chk(rd == exp, "R3 masked read lanes", rd, exp);
        end
      end
    end

    // Intruding requests while busy (R7)
    a = 16'h1357;
    shadow[a ^ 16'h8001] = mem.exists(a ^ 16'h8001) ? mem[a ^ 16'h8001] : 16'h0;
    run(1, a, 16'hBEEF, 2'b11, 1, rd);
    run(0, a, 16'h0, 2'b11, 0, rd);
    chk(rd == 16'hBEEF, "R7 intended write kept", rd, 16'hBEEF);
    run(0, a ^ 16'h8001, 16'h0, 2'b11, 0, rd);
    chk(rd == shadow[a ^ 16'h8001], "R7 intruder ignored", rd, shadow[a ^ 16'h8001]);

    @(negedge clk);
    chk(!busy && sramCeN && sramWeN && sramOeN && !sramDoutEn, "R1 idle at end", busy, 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule